// File: doc/BRIEF.md
# Synchronous PWM Shadow-Register Update Controller

This block decides when freshly written settings reach a group of PWM channels that run in lockstep. Each channel keeps a shadow copy of its period, dead-time and duty-cycle values next to the active copy the counters use. New values are written into the shadows at any time. They are copied into the active registers only on a PWM period boundary, reported by the channel-0 counter as a one-cycle strobe. The copy hits every channel in the same clock, so no channel ever mixes old and new settings.

A two-bit method field selects how duty values are written and what triggers their transfer. In the manual method, software writes the duty values and then sets an unlock flag. In the automatic method, software writes the duty values and a boundary counter triggers the transfer every few periods. In the DMA method, a DMA engine writes the duty values and the boundary counter triggers the transfer. After each transfer in the DMA method, a request is raised to fetch the next set of duty values. That request can optionally wait for a selected comparison-unit match. In all three methods, period and dead-time values move only through the unlock flag.

Top module: `sync_pwm_update_ctrl`

## Requirements
- R1: After reset, every active and shadow value is zero, the method is 0 (manual), the unlock flag reads 0, the counter is zero and `dma_req` is low.
- R2: Writing address 1 with data bit 0 set raises `unlock_pend`. On the next clock edge where `period_end` is high and `unlock_pend` was already 1, every channel copies its period and dead-time shadows into its active outputs. `ld_pd` pulses high for that one cycle and `unlock_pend` clears. Without this, active period and dead-time never change.
- R3: In method 0 (CTRL bits [1:0] = 0, and also for the unused code 3), duty shadows are copied on exactly the same edge as R2, and `ld_duty` pulses with `ld_pd`.
- R4: In methods 1 and 2, a boundary counter advances on each `period_end`. When a boundary arrives with the count at or above the active update period, all duty shadows are copied and `ld_duty` pulses, and the count returns to 0. The unlock flag plays no part in this, so a duty load happens once every update-period-plus-one boundaries.
- R5: The update period is written at address 2 into a shadow. That shadow reaches the active update period on every `period_end` edge, and the counter compare uses it from the following boundary on.
- R6: Duty shadows take CPU writes (address 5) only in methods 0, 1 and 3. They take `dma_wr_en` writes only in method 2. The other source is ignored.
- R7: In method 2 with match sync off, every duty load arms a request. `dma_req` rises one cycle after `ld_duty` and stays high until a cycle with `dma_ack` high.
- R8: With match sync on (CTRL bit 2 = 1), an armed request rises only in the cycle after one where `cmp_match[sel]` is high, where sel is CTRL bits [6:4].
- R9: A shadow write in the same cycle as a load leaves the old shadow value in the active register and keeps the new value in the shadow. An unlock write in the same cycle as `period_end` triggers no load at that boundary.
- R10: Any write to CTRL (address 0) sets the boundary counter back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 CTRL, 1 UNLOCK, 2 UPDATE PERIOD, 3 PERIOD, 4 DEAD-TIME, 5 DUTY |
| wr_ch | input | CHW | Channel index for per-channel writes |
| wr_data | input | VW | Write data |
| dma_wr_en | input | 1 | DMA duty write strobe |
| dma_ch | input | CHW | Channel index of the DMA duty write |
| dma_data | input | VW | DMA duty value |
| dma_req | output | 1 | Request for the next duty values |
| dma_ack | input | 1 | Request acknowledge |
| cmp_match | input | NCMP | Comparison-unit match pulses |
| period_end | input | 1 | Period-boundary strobe from channel 0 |
| ld_pd | output | 1 | Period/dead-time load strobe to the channels |
| ld_duty | output | 1 | Duty load strobe to the channels |
| unlock_pend | output | 1 | Unlock flag readback (load pending) |
| act_period | output | NCH*VW | Active periods, channel i at bits [i*VW +: VW] |
| act_dead | output | NCH*VW | Active dead-times, same packing |
| act_duty | output | NCH*VW | Active duty values, same packing |

## Verification
The collisions that matter are a shadow write landing on a load edge and an unlock write landing on a boundary. Directed steps drive `period_end` in the same cycle as a period write or an unlock write. They then check that the active value holds the old shadow, and that the load waits for the next boundary. A random phase piles CTRL writes, DMA acknowledges and match pulses onto counter boundaries. A behavioural model judges every cycle against all outputs.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_UNLOCK = 3'd1,
    A_UPR    = 3'd2,
    A_PERIOD = 3'd3,
    A_DEAD   = 3'd4,
    A_DUTY   = 3'd5
  } sup_addr_e;

  typedef enum logic [1:0] {
    M_MANUAL = 2'd0,
    M_AUTO   = 2'd1,
    M_DMA    = 2'd2,
    M_SPARE  = 2'd3
  } sup_mode_e;
endpackage

// File: rtl/sup_upd_counter.sv
module sup_upd_counter #(
  parameter int UPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           run,
  input  logic           pe,
  input  logic           upr_we,
  input  logic [UPW-1:0] upr_val,
  output logic           hit
);
  logic [UPW-1:0] upr_sh, upr_act, cnt;

  assign hit = run && pe && (cnt >= upr_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      upr_sh  <= '0;
      upr_act <= '0;
      cnt     <= '0;
    end else begin
      if (upr_we) upr_sh <= upr_val;
      if (pe) upr_act <= upr_sh;
      if (clr) cnt <= '0;
      else if (run && pe) cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> (cnt == '0));
  p_clear_on_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  p_upr_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (pe && !upr_we) |=> (upr_act == upr_sh));
endmodule

// File: rtl/sup_shadow_bank.sv
module sup_shadow_bank #(
  parameter int NCH = 4,
  parameter int VW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_we,
  input  logic              dead_we,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [VW-1:0]     wr_val,
  input  logic              duty_we,
  input  logic [CHW-1:0]    duty_ch,
  input  logic [VW-1:0]     duty_val,
  input  logic              ld_pd,
  input  logic              ld_duty,
  output logic [NCH*VW-1:0] act_period,
  output logic [NCH*VW-1:0] act_dead,
  output logic [NCH*VW-1:0] act_duty
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [VW-1:0] sh_per, sh_dead, sh_duty;
    logic [VW-1:0] ac_per, ac_dead, ac_duty;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_per  <= '0;
        sh_dead <= '0;
        sh_duty <= '0;
        ac_per  <= '0;
        ac_dead <= '0;
        ac_duty <= '0;
      end else begin
        if (ld_pd) begin
          ac_per  <= sh_per;
          ac_dead <= sh_dead;
        end
        if (ld_duty) ac_duty <= sh_duty;
        if (per_we  && wr_ch   == CHW'(i)) sh_per  <= wr_val;
        if (dead_we && wr_ch   == CHW'(i)) sh_dead <= wr_val;
        if (duty_we && duty_ch == CHW'(i)) sh_duty <= duty_val;
      end
    end

    assign act_period[i*VW +: VW] = ac_per;
    assign act_dead[i*VW +: VW]   = ac_dead;
    assign act_duty[i*VW +: VW]   = ac_duty;
  end
endmodule

// File: rtl/sup_dma_req.sv
module sup_dma_req (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic msync,
  input  logic match,
  input  logic ack,
  output logic req
);
  logic arm;
  logic gate;

  assign gate = !msync || match;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm <= 1'b0;
      req <= 1'b0;
    end else begin
      arm <= trig || (arm && !gate);
      req <= (req && !ack) || (arm && gate);
    end
  end

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  p_req_needs_match_r8: assert property (@(posedge clk) disable iff (rst)
    (!req && msync && !match) |=> !req);
endmodule

// File: rtl/sync_pwm_update_ctrl.sv
module sync_pwm_update_ctrl #(
  parameter int NCH  = 4,
  parameter int VW   = 16,
  parameter int UPW  = 4,
  parameter int NCMP = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CSW = (NCMP > 1) ? $clog2(NCMP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [VW-1:0]     wr_data,
  input  logic              dma_wr_en,
  input  logic [CHW-1:0]    dma_ch,
  input  logic [VW-1:0]     dma_data,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [NCMP-1:0]   cmp_match,
  input  logic              period_end,
  output logic              ld_pd,
  output logic              ld_duty,
  output logic              unlock_pend,
  output logic [NCH*VW-1:0] act_period,
  output logic [NCH*VW-1:0] act_dead,
  output logic [NCH*VW-1:0] act_duty
);
  import sup_pkg::*;

  logic [1:0]     mode_q;
  logic           msync_q;
  logic [CSW-1:0] csel_q;
  logic           unlock_q;

  logic wr_ctrl, wr_unl, wr_upr, wr_per, wr_dead, wr_duty;
  logic is_dma, is_auto, cnt_hit, ld_pd_c, ld_duty_c;
  logic           duty_we;
  logic [CHW-1:0] duty_ch;
  logic [VW-1:0]  duty_val;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_unl  = wr_en && (wr_addr == A_UNLOCK) && wr_data[0];
  assign wr_upr  = wr_en && (wr_addr == A_UPR);
  assign wr_per  = wr_en && (wr_addr == A_PERIOD);
  assign wr_dead = wr_en && (wr_addr == A_DEAD);
  assign wr_duty = wr_en && (wr_addr == A_DUTY);

  assign is_dma  = (mode_q == M_DMA);
  assign is_auto = (mode_q == M_AUTO) || (mode_q == M_DMA);

  assign ld_pd_c   = period_end && unlock_q;
  assign ld_duty_c = is_auto ? cnt_hit : ld_pd_c;

  always_comb begin
    if (is_dma) begin
      duty_we  = dma_wr_en;
      duty_ch  = dma_ch;
      duty_val = dma_data;
    end else begin
      duty_we  = wr_duty;
      duty_ch  = wr_ch;
      duty_val = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_MANUAL;
      msync_q  <= 1'b0;
      csel_q   <= '0;
      unlock_q <= 1'b0;
      ld_pd    <= 1'b0;
      ld_duty  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q  <= wr_data[1:0];
        msync_q <= wr_data[2];
        csel_q  <= wr_data[4 +: CSW];
      end
      if (wr_unl) unlock_q <= 1'b1;
      else if (ld_pd_c) unlock_q <= 1'b0;
      ld_pd   <= ld_pd_c;
      ld_duty <= ld_duty_c;
    end
  end

  assign unlock_pend = unlock_q;

  sup_upd_counter #(.UPW(UPW)) u_cnt (
    .clk(clk), .rst(rst), .clr(wr_ctrl), .run(is_auto), .pe(period_end),
    .upr_we(wr_upr), .upr_val(wr_data[UPW-1:0]), .hit(cnt_hit)
  );

  sup_shadow_bank #(.NCH(NCH), .VW(VW)) u_bank (
    .clk(clk), .rst(rst), .per_we(wr_per), .dead_we(wr_dead),
    .wr_ch(wr_ch), .wr_val(wr_data), .duty_we(duty_we), .duty_ch(duty_ch),
    .duty_val(duty_val), .ld_pd(ld_pd_c), .ld_duty(ld_duty_c),
    .act_period(act_period), .act_dead(act_dead), .act_duty(act_duty)
  );

  sup_dma_req u_dma (
    .clk(clk), .rst(rst), .trig(ld_duty_c && is_dma), .msync(msync_q),
    .match(cmp_match[csel_q]), .ack(dma_ack), .req(dma_req)
  );

  p_pd_only_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    ld_pd |-> $past(period_end));
  p_unlock_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_pd && !$past(wr_unl)) |-> !unlock_pend);
  p_pd_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_pd |-> ($stable(act_period) && $stable(act_dead)));
  p_duty_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_duty |-> $stable(act_duty));
  p_manual_duty_with_pd_r3: assert property (@(posedge clk) disable iff (rst)
    (!is_auto && !$past(wr_ctrl)) |-> (ld_duty == ld_pd));
endmodule

// File: tb/sync_pwm_update_ctrl_test.sv
module sync_pwm_update_ctrl_test;
  localparam int NCH = 4, VW = 16, UPW = 4, NCMP = 8, CHW = 2, CSW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0; logic [2:0] wr_addr = 0; logic [CHW-1:0] wr_ch = 0; logic [VW-1:0] wr_data = 0;
  logic dma_wr_en = 0; logic [CHW-1:0] dma_ch = 0; logic [VW-1:0] dma_data = 0;
  logic dma_ack = 0; logic [NCMP-1:0] cmp_match = 0; logic period_end = 0;
  logic dma_req, ld_pd, ld_duty, unlock_pend;
  logic [NCH*VW-1:0] act_period, act_dead, act_duty;

  always #2 clk = ~clk;

  sync_pwm_update_ctrl #(.NCH(NCH), .VW(VW), .UPW(UPW), .NCMP(NCMP)) uut (.*);

  int compared = 0, mismatched = 0;
  string phase = "R1";

  // behavioural reference model
  int m_shp[NCH], m_shd[NCH], m_shu[NCH], m_ap[NCH], m_ad[NCH], m_au[NCH];
  int m_mode, m_ms, m_cs, m_unl, m_upr_sh, m_upr_act, m_cnt, m_arm, m_req, m_lpd, m_ldu;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_shp[i] = 0; m_shd[i] = 0; m_shu[i] = 0; m_ap[i] = 0; m_ad[i] = 0; m_au[i] = 0;
      end
      m_mode = 0; m_ms = 0; m_cs = 0; m_unl = 0; m_upr_sh = 0; m_upr_act = 0;
      m_cnt = 0; m_arm = 0; m_req = 0; m_lpd = 0; m_ldu = 0;
    end else begin
      bit auto_m, dma_m, lp, ldu, gate, ctrl_w;
      auto_m = (m_mode == 1 || m_mode == 2);
      dma_m  = (m_mode == 2);
      lp     = period_end && m_unl != 0;
      ldu    = auto_m ? (period_end && m_cnt >= m_upr_act) : lp;
      gate   = (m_ms == 0) || cmp_match[m_cs];
      ctrl_w = wr_en && wr_addr == 0;
      for (int i = 0; i < NCH; i++) begin
        if (lp) begin m_ap[i] = m_shp[i]; m_ad[i] = m_shd[i]; end
        if (ldu) m_au[i] = m_shu[i];
      end
      if (ctrl_w) m_cnt = 0;
      else if (auto_m && period_end) m_cnt = ldu ? 0 : m_cnt + 1;
      if (period_end) m_upr_act = m_upr_sh;
      m_req = ((m_req != 0 && !dma_ack) || (m_arm != 0 && gate)) ? 1 : 0;
      m_arm = ((ldu && dma_m) || (m_arm != 0 && !gate)) ? 1 : 0;
      m_lpd = lp; m_ldu = ldu;
      if (wr_en && wr_addr == 1 && wr_data[0]) m_unl = 1;
      else if (lp) m_unl = 0;
      if (wr_en) begin
        case (wr_addr)
          0: begin m_mode = wr_data[1:0]; m_ms = wr_data[2]; m_cs = wr_data[4 +: CSW]; end
          2: m_upr_sh = wr_data[UPW-1:0];
          3: m_shp[wr_ch] = wr_data;
          4: m_shd[wr_ch] = wr_data;
          5: if (!dma_m) m_shu[wr_ch] = wr_data;
          default: ;
        endcase
      end
      if (dma_wr_en && dma_m) m_shu[dma_ch] = dma_data;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) if (!rst) begin
    for (int i = 0; i < NCH; i++) begin
      chk({phase, " R2 act_period"}, act_period[i*VW +: VW], m_ap[i]);
      chk({phase, " R2 act_dead"}, act_dead[i*VW +: VW], m_ad[i]);
      chk({phase, " R3 R4 act_duty"}, act_duty[i*VW +: VW], m_au[i]);
    end
    chk({phase, " R2 ld_pd"}, ld_pd, m_lpd);
    chk({phase, " R4 ld_duty"}, ld_duty, m_ldu);
    chk({phase, " R2 unlock_pend"}, unlock_pend, m_unl);
    chk({phase, " R7 dma_req"}, dma_req, m_req);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int ch, input int d, input bit pe = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_ch = ch[CHW-1:0]; wr_data = d[VW-1:0]; period_end = pe;
    @(negedge clk);
    wr_en = 0; period_end = 0;
  endtask

  task automatic pe_pulse();
    @(negedge clk); period_end = 1;
    @(negedge clk); period_end = 0;
    idle(2);
  endtask

  task automatic dwr(input int ch, input int d);
    @(negedge clk); dma_wr_en = 1; dma_ch = ch[CHW-1:0]; dma_data = d[VW-1:0];
    @(negedge clk); dma_wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset act_period", int'(act_period), 0);
    chk("R1 reset act_duty", int'(act_duty), 0);
    chk("R1 reset dma_req", dma_req, 0);
    chk("R1 reset unlock_pend", unlock_pend, 0);

    phase = "R2";
    for (int i = 0; i < NCH; i++) begin
      wr(3, i, 100 + i); wr(4, i, 10 + i); wr(5, i, 50 + i);
    end
    pe_pulse();
    chk("R2 no load without unlock", int'(act_period[2*VW +: VW]), 0);
    wr(1, 0, 1);
    chk("R2 unlock reads 1", unlock_pend, 1);
    pe_pulse();
    chk("R2 period ch2", int'(act_period[2*VW +: VW]), 102);
    chk("R2 dead ch1", int'(act_dead[1*VW +: VW]), 11);
    chk("R3 duty ch3 loaded in manual mode", int'(act_duty[3*VW +: VW]), 53);
    chk("R2 unlock cleared", unlock_pend, 0);

    phase = "R9";
    wr(3, 0, 200);
    wr(1, 0, 1);
    wr(3, 0, 300, 1);
    chk("R9 old shadow loaded", int'(act_period[0 +: VW]), 200);
    wr(1, 0, 1, 1);
    idle(1);
    chk("R9 unlock at boundary no load", int'(act_period[0 +: VW]), 200);
    chk("R9 unlock still pending", unlock_pend, 1);
    pe_pulse();
    chk("R9 new shadow loaded later", int'(act_period[0 +: VW]), 300);

    phase = "R4";
    wr(0, 0, 1);
    wr(2, 0, 2);
    for (int i = 0; i < NCH; i++) wr(5, i, 70 + i);
    pe_pulse();
    phase = "R5";
    for (int k = 0; k < 6; k++) pe_pulse();
    chk("R4 duty loaded without unlock", int'(act_duty[1*VW +: VW]), 71);
    phase = "R10";
    wr(5, 0, 77);
    pe_pulse(); wr(0, 0, 1); pe_pulse(); pe_pulse(); pe_pulse();
    phase = "R6";
    wr(0, 0, 1);
    dwr(1, 555);
    for (int k = 0; k < 3; k++) pe_pulse();
    chk("R6 DMA write ignored in method 1", int'(act_duty[1*VW +: VW]), 71);

    phase = "R7";
    wr(0, 0, 2);
    wr(2, 0, 0);
    wr(5, 1, 999);
    dwr(1, 42);
    pe_pulse(); pe_pulse();
    chk("R6 DMA duty in method 2", int'(act_duty[1*VW +: VW]), 42);
    chk("R7 request raised", dma_req, 1);
    idle(3);
    chk("R7 request held", dma_req, 1);
    @(negedge clk); dma_ack = 1; @(negedge clk); dma_ack = 0;
    chk("R7 request dropped on ack", dma_req, 0);

    phase = "R8";
    wr(0, 0, 2 | 4 | (3 << 4));
    pe_pulse(); pe_pulse();
    idle(3);
    chk("R8 waits for match", dma_req, 0);
    @(negedge clk); cmp_match = 8'h01; @(negedge clk); cmp_match = 8'h08;
    @(negedge clk); cmp_match = 0;
    chk("R8 request after selected match", dma_req, 1);
    @(negedge clk); dma_ack = 1; @(negedge clk); dma_ack = 0;

    phase = "RAND";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      period_end = ($urandom_range(0, 4) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = 3'($urandom_range(0, 6));
      if (wr_addr == 0 && $urandom_range(0, 3) != 0) wr_en = 0;
      wr_ch = CHW'($urandom);
      wr_data = (wr_addr == 2) ? VW'($urandom_range(0, 3)) : VW'($urandom);
      dma_wr_en = $urandom_range(0, 1);
      dma_ch = CHW'($urandom);
      dma_data = VW'($urandom);
      dma_ack = ($urandom_range(0, 3) == 0);
      cmp_match = NCMP'($urandom) & NCMP'($urandom);
    end
    @(negedge clk);
    wr_en = 0; dma_wr_en = 0; period_end = 0; dma_ack = 0; cmp_match = 0;
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule